// File: doc/BRIEF.md
# Synchronous Slave Serial Receiver

This block receives serial words from an external master that drives both a bit clock and a data line. Both lines are brought into the system clock domain through two-stage synchronizers. Optional polarity inversion is then applied to each line. Every rising edge of the resulting effective bit clock samples one data bit, least significant bit first, into an accumulator. When the last bit of a word arrives, the word moves into a holding register and a receive-complete flag is raised.

Words are 8 or 9 bits long. In 9-bit mode the extra bit is reported on its own output next to the 8-bit data. Software reads a word by pulsing a read strobe, and that strobe clears the flag. An interrupt request follows the flag when interrupts are enabled.

A word that completes while the previous one is still unread is thrown away. That event sets an overrun error, which freezes reception until software drops the receive enable. Dropping the enable also discards any half-received word.

Top module: `sync_slave_rx`

## Requirements
- R1: After a synchronous active-low reset, the data output, the ninth-bit output, the receive-complete flag, the overrun error and the interrupt request are all 0.
- R2: While `rx_enable` is 0, bit-clock edges do not change any output. The `single_req` input has no effect at any time.
- R3: When `nine_bit` is 1, a word is 9 bits long, and the ninth bit received (bit index 8) appears on `rx_bit8`. When `nine_bit` is 0, a word is 8 bits long and `rx_bit8` is loaded with 0.
- R4: Bits are taken on each rising edge of the effective bit clock, least significant bit first. On the last bit of a word, the word is loaded into `rx_data`/`rx_bit8` and `rx_full` is set. This happens no later than 4 system clocks after the edge reaches the pin.
- R5: When `clk_invert` is 1, the effective bit clock is the inverse of `ser_clk`, so data is taken on a falling pin edge. When `data_invert` is 1, each sampled bit is the inverse of the `ser_data` pin level.
- R6: `irq` is 1 exactly when `rx_full` is 1 and `int_enable` is 1.
- R7: A one-cycle `rd_strobe` clears `rx_full` on the next clock, unless a new word completes in the same cycle.
- R8: If a word completes while `rx_full` is 1 and no read happens in that cycle, the word is discarded, `rx_data` keeps its value and `overrun` is set. No further word is accepted while `overrun` is 1.
- R9: Setting `rx_enable` to 0 clears `overrun` on the next clock and resets the bit count, so a partly received word is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Bit clock from the external master |
| ser_data | input | 1 | Serial data from the external master |
| rx_enable | input | 1 | Continuous-receive enable; also clears the error |
| single_req | input | 1 | Single-receive request; ignored in slave operation |
| nine_bit | input | 1 | 1 selects 9-bit words |
| clk_invert | input | 1 | Invert the bit clock before edge detection |
| data_invert | input | 1 | Invert the data before sampling |
| int_enable | input | 1 | Receive interrupt enable |
| rd_strobe | input | 1 | One-cycle read of the data register; clears the flag |
| rx_data | output | 8 | Received data, low 8 bits |
| rx_bit8 | output | 1 | Ninth received bit |
| rx_full | output | 1 | Receive-complete flag |
| overrun | output | 1 | Overrun error |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is an overrun followed by a further attempted word. It requires one word to sit unread while a second full word is clocked in. A third word must then be sent while the error holds. The bench does exactly this and checks that the data register keeps the first word throughout. It then drops the enable in the middle of a later word to show that the error clears and the partial bits are lost. A behavioural reference model follows the pin-to-flag latency on every clock, so an off-by-one in the synchronizer depth, the bit count or the flag timing shows up as a mismatch at once.

// File: rtl/sslv_pkg.sv
// Package: shared constants and helpers for the synchronous slave receiver.
// Assumes: nothing beyond IEEE 1800-2017.
package sslv_pkg;
    localparam int SYNC_STAGES_DEF = 2;
    localparam int DATA_W_DEF      = 8;

    // Applies an optional polarity inversion to a single line.
    function automatic logic apply_pol(input logic level, input logic inv);
        return level ^ inv;
    endfunction
endpackage

// File: rtl/sslv_front.sv
// Module: sslv_front
// Brings the external bit clock and data lines into the system clock domain
// through a synchronizer chain, applies the polarity selects and flags the
// rising edge of the effective bit clock together with the sampled bit.
// Assumes: the master holds data stable across the synchronizer latency
// around each active clock edge.
module sslv_front
    import sslv_pkg::*;
#(
    parameter int STAGES = SYNC_STAGES_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_clk,
    input  logic pin_dat,
    input  logic clk_inv,
    input  logic dat_inv,
    output logic bit_rise,
    output logic bit_val
);
    localparam int NSIG = 2;

    logic [NSIG-1:0] raw_in;
    logic [NSIG-1:0] synced;
    logic            eff_clk;
    logic            eff_prev;

    assign raw_in = {pin_dat, pin_clk};

    for (genvar g = 0; g < NSIG; g++) begin : g_sync
        logic [STAGES-1:0] chain;
        // Shifts the line through the synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], raw_in[g]};
        end
        assign synced[g] = chain[STAGES-1];
    end

    assign eff_clk = apply_pol(synced[0], clk_inv);
    assign bit_val = apply_pol(synced[1], dat_inv);

    // Remembers the previous effective clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) eff_prev <= 1'b0;
        else        eff_prev <= eff_clk;
    end

    assign bit_rise = eff_clk & ~eff_prev;
endmodule

// File: rtl/sslv_shifter.sv
// Module: sslv_shifter
// Accumulates sampled bits LSB first and emits a one-cycle done pulse with
// the finished word. Holds still while halted; clears when disabled.
// Assumes: bit_rise is a single-cycle pulse.
module sslv_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              halt,
    input  logic              nine,
    input  logic              bit_rise,
    input  logic              bit_val,
    output logic              done,
    output logic [DATA_W:0]   word
);
    localparam int WORD_W = DATA_W + 1;
    localparam int CNT_W  = $clog2(WORD_W + 1);

    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-1:0] acc;
    logic [WORD_W-1:0] bit_vec;
    logic              last;

    assign bit_vec = WORD_W'(bit_val) << cnt;
    assign last    = nine ? (cnt == CNT_W'(DATA_W)) : (cnt == CNT_W'(DATA_W - 1));

    // Counts bits, collects them and hands over the finished word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            acc  <= '0;
            done <= 1'b0;
            word <= '0;
        end else begin
            done <= 1'b0;
            if (!enable) begin
                cnt <= '0;
                acc <= '0;
            end else if (bit_rise && !halt) begin
                if (last) begin
                    cnt  <= '0;
                    acc  <= '0;
                    done <= 1'b1;
                    word <= acc | bit_vec;
                end else begin
                    cnt <= cnt + 1'b1;
                    acc <= acc | bit_vec;
                end
            end
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DATA_W)); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4
    AST_OFF_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (cnt == '0)); // R9
endmodule

// File: rtl/sslv_holding.sv
// Module: sslv_holding
// Holding register for finished words with the receive-complete flag and the
// overrun error. A read clears the flag; dropping enable clears the error.
// Assumes: done is a single-cycle pulse from the shifter.
module sslv_holding #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              done,
    input  logic [DATA_W:0]   word,
    input  logic              rd,
    output logic [DATA_W-1:0] data_q,
    output logic              bit8_q,
    output logic              full_q,
    output logic              err_q
);
    logic unread;

    assign unread = full_q & ~rd;

    // Loads a finished word or clears the flag on a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            bit8_q <= 1'b0;
            full_q <= 1'b0;
        end else if (done && !unread) begin
            data_q <= word[DATA_W-1:0];
            bit8_q <= word[DATA_W];
            full_q <= 1'b1;
        end else if (rd) begin
            full_q <= 1'b0;
        end
    end

    // Sets the overrun error on a lost word; clears it when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)                        err_q <= 1'b0;
        else if (!enable)                  err_q <= 1'b0;
        else if (done && unread)           err_q <= 1'b1;
    end

    AST_FLAG_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> full_q); // R4
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !done) |=> !full_q); // R7
    AST_DATA_HELD_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && enable) |=> $stable(data_q)); // R8
    AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !err_q); // R9
endmodule

// File: rtl/sync_slave_rx.sv
// Module: sync_slave_rx (top)
// Synchronous slave serial receiver: front end (synchronizers, polarity,
// edge detect), bit shifter and holding register with flag and error.
// Assumes: ser_clk toggles no faster than once per STAGES+1 system clocks.
module sync_slave_rx
    import sslv_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF,
    parameter int STAGES = SYNC_STAGES_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              rx_enable,
    input  logic              single_req,
    input  logic              nine_bit,
    input  logic              clk_invert,
    input  logic              data_invert,
    input  logic              int_enable,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_bit8,
    output logic              rx_full,
    output logic              overrun,
    output logic              irq
);
    logic            bit_rise;
    logic            bit_val;
    logic            word_done;
    logic [DATA_W:0] word;
    logic            unused_ok;

    assign unused_ok = single_req;

    sslv_front #(.STAGES(STAGES)) u_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_clk  (ser_clk),
        .pin_dat  (ser_data),
        .clk_inv  (clk_invert),
        .dat_inv  (data_invert),
        .bit_rise (bit_rise),
        .bit_val  (bit_val)
    );

    sslv_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (rx_enable),
        .halt     (overrun),
        .nine     (nine_bit),
        .bit_rise (bit_rise),
        .bit_val  (bit_val),
        .done     (word_done),
        .word     (word)
    );

    sslv_holding #(.DATA_W(DATA_W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (rx_enable),
        .done   (word_done),
        .word   (word),
        .rd     (rd_strobe),
        .data_q (rx_data),
        .bit8_q (rx_bit8),
        .full_q (rx_full),
        .err_q  (overrun)
    );

    assign irq = rx_full & int_enable;

    AST_NO_IRQ_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_full |-> !irq); // R6
    AST_OFF_NO_NEW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_enable && $past(!rx_enable) && !rx_full) |=> !rx_full); // R2
endmodule

// File: tb/sync_slave_rx_test.sv
module sync_slave_rx_test;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       ser_clk = 0, ser_data = 0;
    logic       rx_enable = 0, single_req = 0, nine_bit = 0;
    logic       clk_invert = 0, data_invert = 0, int_enable = 0, rd_strobe = 0;
    logic [7:0] rx_data;
    logic       rx_bit8, rx_full, overrun, irq;

    int checks = 0;
    int fails  = 0;

    sync_slave_rx uut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .rx_enable(rx_enable), .single_req(single_req), .nine_bit(nine_bit),
        .clk_invert(clk_invert), .data_invert(data_invert),
        .int_enable(int_enable), .rd_strobe(rd_strobe),
        .rx_data(rx_data), .rx_bit8(rx_bit8), .rx_full(rx_full),
        .overrun(overrun), .irq(irq)
    );

    always #5 clk = ~clk;

    // Behavioural reference model state
    bit       m_c1, m_c2, m_d1, m_d2, m_prev, m_done;
    int       m_cnt;
    int       m_bits;
    int       m_word;
    bit [7:0] m_data;
    bit       m_b8, m_flag, m_err;
    bit       model_on = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_c1 = 0; m_c2 = 0; m_d1 = 0; m_d2 = 0; m_prev = 0; m_done = 0;
            m_cnt = 0; m_bits = 0; m_word = 0;
            m_data = 0; m_b8 = 0; m_flag = 0; m_err = 0;
        end else begin
            bit err_old, eff, rise, b, nd;
            int len;
            err_old = m_err;
            if (m_done) begin
                if (m_flag && !rd_strobe) begin
                    if (rx_enable) m_err = 1;
                end else begin
                    m_data = m_word[7:0]; m_b8 = m_word[8]; m_flag = 1;
                end
            end else if (rd_strobe) m_flag = 0;
            if (!rx_enable) m_err = 0;
            eff = m_c2 ^ clk_invert;
            rise = eff && !m_prev;
            m_prev = eff;
            b = m_d2 ^ data_invert;
            len = nine_bit ? 9 : 8;
            nd = 0;
            if (!rx_enable) begin
                m_cnt = 0; m_bits = 0;
            end else if (rise && !err_old) begin
                m_bits = m_bits | (int'(b) << m_cnt);
                if (m_cnt == len - 1) begin
                    m_word = m_bits; nd = 1; m_cnt = 0; m_bits = 0;
                end else m_cnt = m_cnt + 1;
            end
            m_done = nd;
            m_c2 = m_c1; m_c1 = ser_clk;
            m_d2 = m_d1; m_d1 = ser_data;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model, away from the edge
    always @(posedge clk) begin
        #3;
        if (model_on && rst_n) begin
            chk("R4 data", rx_data, m_data);
            chk("R3 bit8", rx_bit8, m_b8);
            chk("R7 flag", rx_full, m_flag);
            chk("R8 overrun", overrun, m_err);
            chk("R6 irq", irq, m_flag && int_enable);
        end
    end

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_bit(input bit b);
        ser_data = b ^ data_invert;
        wait_n(3);
        ser_clk = ~clk_invert;
        wait_n(3);
        ser_clk = clk_invert;
        wait_n(1);
    endtask

    task automatic send_word(input int v, input int n);
        for (int i = 0; i < n; i++) send_bit(v[i]);
        wait_n(5);
    endtask

    task automatic do_read();
        rd_strobe = 1;
        wait_n(1);
        rd_strobe = 0;
        wait_n(1);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait_n(3);
        rst_n = 1;
        wait_n(1);
        model_on = 1;
        // R1 reset state
        chk("R1 data", rx_data, 0);
        chk("R1 full", rx_full, 0);
        chk("R1 err", overrun, 0);
        chk("R1 irq", irq, 0);

        // R2 disabled: no effect, single_req ignored
        single_req = 1;
        send_word(8'hA5, 8);
        chk("R2 full", rx_full, 0);
        chk("R2 data", rx_data, 0);

        // R4 plain 8-bit word LSB first, R6 irq
        rx_enable = 1; int_enable = 1; single_req = 0;
        wait_n(4);
        send_word(8'h3C, 8);
        chk("R4 data", rx_data, 8'h3C);
        chk("R4 full", rx_full, 1);
        chk("R6 irq on", irq, 1);
        do_read();
        chk("R7 cleared", rx_full, 0);
        chk("R6 irq off", irq, 0);

        int_enable = 0; single_req = 1;
        send_word(8'h81, 8);
        chk("R4 data 81", rx_data, 8'h81);
        chk("R6 irq masked", irq, 0);
        do_read();
        single_req = 0;

        // R3 nine-bit words
        nine_bit = 1;
        send_word(9'h1A5, 9);
        chk("R3 data", rx_data, 8'hA5);
        chk("R3 bit8 one", rx_bit8, 1);
        do_read();
        send_word(9'h05A, 9);
        chk("R3 bit8 zero", rx_bit8, 0);
        chk("R3 data 5A", rx_data, 8'h5A);
        do_read();
        nine_bit = 0;

        // R5 inversions, changed only while disabled
        rx_enable = 0; clk_invert = 1; data_invert = 1; ser_clk = 1;
        wait_n(6);
        rx_enable = 1;
        wait_n(2);
        send_word(8'h6E, 8);
        chk("R5 both inverted", rx_data, 8'h6E);
        do_read();
        rx_enable = 0; data_invert = 0;
        wait_n(6);
        rx_enable = 1;
        wait_n(2);
        send_word(8'hC3, 8);
        chk("R5 clock inverted", rx_data, 8'hC3);
        do_read();
        rx_enable = 0; clk_invert = 0; ser_clk = 0;
        wait_n(6);
        rx_enable = 1;
        wait_n(2);

        // R8 overrun
        send_word(8'h11, 8);
        send_word(8'h22, 8);
        chk("R8 err set", overrun, 1);
        chk("R8 data kept", rx_data, 8'h11);
        send_word(8'h33, 8);
        chk("R8 halted", rx_data, 8'h11);
        do_read();
        chk("R8 err holds", overrun, 1);
        rx_enable = 0;
        wait_n(2);
        chk("R9 err cleared", overrun, 0);

        // R9 partial word dropped
        rx_enable = 1;
        wait_n(2);
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        rx_enable = 0;
        wait_n(3);
        rx_enable = 1;
        wait_n(2);
        send_word(8'h40, 8);
        chk("R9 partial dropped", rx_data, 8'h40);
        chk("R9 full", rx_full, 1);
        do_read();

        wait_n(4);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule